// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block computes a single-error-correcting, double-error-detecting code over a whole NAND page. It watches the flash data bus and counts each qualified data beat as one page word. In 8-bit bus mode a word is one byte. In 16-bit bus mode a word is one 16-bit bus word. One code protects the entire page in a single step. The page length is picked from four sizes.

For each set data bit the engine folds the bit's position into a 16-bit parity value. The position is a 12-bit word offset and a 4-bit bit index. It folds the complement of that position into a second 16-bit value. After a page write, software reads these two values and stores them in the spare area as four code bytes.

On a page read, the stored code beats must follow directly after the last data beat. The engine compares them with the parity it computed and sorts the page into one of four outcomes:
- clean;
- one flipped data bit, with its location reported;
- one flipped bit in the stored code;
- an uncorrectable multiple error.

An erased page of all ones is reported as clean. The result stays frozen until software clears the engine through the control register.

Top module: `necc_page_ecc`

## Requirements
- R1: After reset, every register reads zero. This means mode field 0 (528-byte page, 8-bit bus), status 0, parity 0 and check parity 0. The register selector values are 0 control, 1 mode, 2 status, 3 parity, 4 check parity, and any other value reads zero.
- R2: While a page is in progress, parity (selector 3) reads the running XOR, over every set data bit, of the 16-bit position {word offset[11:0], bit index[3:0]}. Check parity (selector 4) reads the XOR of the complements of those positions. Word offsets are taken modulo 4096. In 8-bit mode only bus bits 7:0 count.
- R3: A beat counts only when `bus_strobe` and `bus_data_phase` are both high in the same cycle. Strobes on command or address cycles, and data-phase cycles without a strobe, change nothing.
- R4: Mode bits 1:0 select a page of 528 shifted left by that value bytes (528, 1056, 2112 or 4224). The page holds that many beats in 8-bit mode and half as many in 16-bit mode. The beats after the page are taken as the code. In 8-bit mode this is four bytes: parity low, parity high, check parity low, check parity high. In 16-bit mode it is two words: parity, then check parity. The result appears only once the last code beat is taken.
- R5: When the stored code matches the computed one, status (selector 2) reads 0 and parity reads 0.
- R6: A single flipped data bit gives status 1, with bit 0 as the recoverable flag. Parity then reads {word offset, bit index} of the flipped bit, and check parity reads its complement.
- R7: A stored code that differs from the computed one in exactly one bit gives status 3: recoverable flag plus bit 1, the code-error flag.
- R8: Any other nonzero mismatch gives status 5: recoverable flag plus bit 2, the multiple-error flag. Parity reads the XOR syndrome. The one exception is R9.
- R9: An otherwise multiple-error result whose parity syndrome is all ones is an erased page, and status reads 0.
- R10: A write to control with bit 0 set, or any write to mode, clears the parity, the stored code and the beat count. Mode bit 4 selects the 16-bit bus. The clear wins over a beat strobed in the same cycle.
- R11: Once the result is out, further beats are ignored. Status, parity and check parity hold their values, and reading them has no side effect.
- R12: In 16-bit mode the mode register reads back bit 4 set. Offsets count 16-bit words, and a flipped bit in the upper byte reports bit index 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_strobe | input | 1 | Flash bus beat strobe |
| bus_data_phase | input | 1 | High on data cycles, low on command and address cycles |
| bus_dq | input | 16 | Flash bus data; bits 7:0 only in 8-bit mode |
| reg_sel | input | 3 | Register selector |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |

## Verification
The assertions assume three things about the inputs:
- the mode is never rewritten without the page being cleared, which the mode write itself guarantees;
- code beats arrive only after the last data beat of the page;
- register reads never overlap a register write in the same cycle.

The stimulus changes the mode only through register writes between pages. It always sends complete pages followed by their code beats. It inserts command-phase strobes and strobe-less data cycles only as noise. Reads are taken between clock edges with the write strobe low.

// File: rtl/necc_pkg.sv
`timescale 1ns/1ps
package necc_pkg;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_CODE = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_MODE = 3'd1,
    SEL_STAT = 3'd2,
    SEL_PAR  = 3'd3,
    SEL_CPAR = 3'd4
  } sel_e;

  typedef struct packed {
    logic multi;
    logic in_code;
    logic recov;
  } flags_t;

endpackage

// File: rtl/necc_fold.sv
`timescale 1ns/1ps
// Folds one bus beat into a parity contribution: the XOR of the positions
// of all set bits, plus the oddness of the set-bit count.
module necc_fold #(
  parameter int DQ_W    = 16,
  parameter int WADDR_W = 12,
  parameter int BIT_W   = 4
) (
  input  logic [WADDR_W-1:0]       word_idx,
  input  logic [DQ_W-1:0]          dq,
  input  logic                     wide,
  output logic [WADDR_W+BIT_W-1:0] contrib,
  output logic                     odd
);
  localparam int SYN_W  = WADDR_W + BIT_W;
  localparam int HALF_W = DQ_W / 2;

  logic [DQ_W-1:0]  live;
  logic [SYN_W-1:0] term [DQ_W];

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    if (i < HALF_W) begin : g_low
      assign live[i] = dq[i];
    end else begin : g_high
      assign live[i] = dq[i] & wide;
    end
    assign term[i] = live[i] ? {word_idx, BIT_W'(i)} : '0;
  end

  always_comb begin
    contrib = '0;
    odd     = 1'b0;
    for (int i = 0; i < DQ_W; i++) begin
      contrib = contrib ^ term[i];
      odd     = odd ^ live[i];
    end
  end
endmodule

// File: rtl/necc_seq.sv
`timescale 1ns/1ps
// Beat counter and page phase: data beats, then code beats, then frozen.
module necc_seq import necc_pkg::*; #(
  parameter int CNT_W   = 13,
  parameter int WADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               clr,
  input  logic               take,
  input  logic               wide,
  input  logic [CNT_W-1:0]   page_words,
  output phase_e             phase,
  output logic [WADDR_W-1:0] word_idx,
  output logic [1:0]         slot,
  output logic               acc_en,
  output logic               cap_en
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       slot_q, slot_d;
  logic [1:0]       slot_last;
  logic             upd;

  assign slot_last = wide ? 2'd1 : 2'd3;
  assign acc_en    = take && !clr && (ph_q == PH_DATA);
  assign cap_en    = take && !clr && (ph_q == PH_CODE);
  assign upd       = clr || acc_en || cap_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (clr) begin
      ph_d   = PH_DATA;
      cnt_d  = '0;
      slot_d = '0;
    end else if (acc_en) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == page_words - CNT_W'(1)) ph_d = PH_CODE;
    end else if (cap_en) begin
      slot_d = slot_q + 2'd1;
      if (slot_q == slot_last) ph_d = PH_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_DATA;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (upd) begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

  assign phase    = ph_q;
  assign word_idx = cnt_q[WADDR_W-1:0];
  assign slot     = slot_q;

  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!take && !clr) |=> ($stable(cnt_q) && $stable(slot_q) && $stable(ph_q)));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_DATA) |-> (cnt_q < page_words));

  p_clear_restart_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (ph_q == PH_DATA && cnt_q == '0 && slot_q == '0));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (ph_q == PH_DONE && !clr) |=> (ph_q == PH_DONE));
endmodule

// File: rtl/necc_judge.sv
`timescale 1ns/1ps
// Compares computed and stored code and sorts the outcome.
module necc_judge import necc_pkg::*; #(
  parameter int SYN_W = 16
) (
  input  logic [SYN_W-1:0] calc_p,
  input  logic [SYN_W-1:0] calc_np,
  input  logic [SYN_W-1:0] store_p,
  input  logic [SYN_W-1:0] store_np,
  output logic [SYN_W-1:0] syn,
  output logic [SYN_W-1:0] nsyn,
  output flags_t           flags
);
  always_comb begin
    syn   = calc_p ^ store_p;
    nsyn  = calc_np ^ store_np;
    flags = '0;
    if ((syn | nsyn) == '0) begin
      flags = '0;
    end else if ((syn ^ nsyn) == '1) begin
      flags.recov = 1'b1;
    end else if ($countones({syn, nsyn}) == 1) begin
      flags.recov   = 1'b1;
      flags.in_code = 1'b1;
    end else if (syn == '1) begin
      flags = '0;
    end else begin
      flags.recov = 1'b1;
      flags.multi = 1'b1;
    end
  end
endmodule

// File: rtl/necc_page_ecc.sv
`timescale 1ns/1ps
module necc_page_ecc import necc_pkg::*; #(
  parameter int DQ_W      = 16,
  parameter int WADDR_W   = 12,
  parameter int PAGE_BASE = 528,
  parameter int SIZE_W    = 2,
  parameter int REG_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_strobe,
  input  logic             bus_data_phase,
  input  logic [DQ_W-1:0]  bus_dq,
  input  logic [2:0]       reg_sel,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int BIT_W    = $clog2(DQ_W);
  localparam int SYN_W    = WADDR_W + BIT_W;
  localparam int CODE_W   = 2 * SYN_W;
  localparam int BYTE_W   = 8;
  localparam int WIDE_BIT = 4;
  localparam int CNT_W    = $clog2((PAGE_BASE << ((1 << SIZE_W) - 1)) + 1);

  // internal reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  // register writes
  logic clr, mode_wr, wdata_unused;
  assign mode_wr = reg_we && (reg_sel == SEL_MODE);
  assign clr     = mode_wr || (reg_we && (reg_sel == SEL_CTRL) && reg_wdata[0]);
  assign wdata_unused = ^{reg_wdata[REG_W-1:WIDE_BIT+1], reg_wdata[WIDE_BIT-1:SIZE_W]};

  logic [SIZE_W-1:0] size_q;
  logic              wide_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      wide_q <= 1'b0;
    end else if (mode_wr) begin
      size_q <= reg_wdata[SIZE_W-1:0];
      wide_q <= reg_wdata[WIDE_BIT];
    end
  end

  logic [CNT_W-1:0] page_bytes, page_words;
  assign page_bytes = CNT_W'(PAGE_BASE) << size_q;
  assign page_words = wide_q ? (page_bytes >> 1) : page_bytes;

  // sequencing
  phase_e             phase;
  logic [WADDR_W-1:0] word_idx;
  logic [1:0]         slot;
  logic               acc_en, cap_en;

  necc_seq #(.CNT_W(CNT_W), .WADDR_W(WADDR_W)) u_seq (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .clr        (clr),
    .take       (bus_strobe && bus_data_phase),
    .wide       (wide_q),
    .page_words (page_words),
    .phase      (phase),
    .word_idx   (word_idx),
    .slot       (slot),
    .acc_en     (acc_en),
    .cap_en     (cap_en)
  );

  // parity accumulation
  logic [SYN_W-1:0] contrib;
  logic             odd;
  necc_fold #(.DQ_W(DQ_W), .WADDR_W(WADDR_W), .BIT_W(BIT_W)) u_fold (
    .word_idx (word_idx),
    .dq       (bus_dq),
    .wide     (wide_q),
    .contrib  (contrib),
    .odd      (odd)
  );

  logic [SYN_W-1:0]  par_q, par_d, npar_q, npar_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              par_en, code_en;

  assign par_en  = clr || acc_en;
  assign code_en = clr || cap_en;

  always_comb begin
    par_d  = par_q;
    npar_d = npar_q;
    if (clr) begin
      par_d  = '0;
      npar_d = '0;
    end else if (acc_en) begin
      par_d  = par_q ^ contrib;
      npar_d = npar_q ^ contrib ^ {SYN_W{odd}};
    end
  end

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (cap_en) begin
      if (wide_q) code_d[slot[0]*DQ_W +: DQ_W] = bus_dq;
      else        code_d[slot*BYTE_W +: BYTE_W] = bus_dq[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q  <= '0;
      npar_q <= '0;
    end else if (par_en) begin
      par_q  <= par_d;
      npar_q <= npar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  // outcome
  logic [SYN_W-1:0] syn, nsyn;
  flags_t           flags;
  necc_judge #(.SYN_W(SYN_W)) u_judge (
    .calc_p   (par_q),
    .calc_np  (npar_q),
    .store_p  (code_q[SYN_W-1:0]),
    .store_np (code_q[CODE_W-1:SYN_W]),
    .syn      (syn),
    .nsyn     (nsyn),
    .flags    (flags)
  );

  logic done;
  assign done = (phase == PH_DONE);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_MODE: reg_rdata = REG_W'({wide_q, {(WIDE_BIT-SIZE_W){1'b0}}, size_q});
      SEL_STAT: reg_rdata = done ? REG_W'(flags) : '0;
      SEL_PAR:  reg_rdata = REG_W'(done ? syn : par_q);
      SEL_CPAR: reg_rdata = REG_W'(done ? nsyn : npar_q);
      default:  reg_rdata = '0;
    endcase
  end

  p_done_frozen_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && !clr) |=> ($stable(par_q) && $stable(npar_q) && $stable(code_q)));

  p_clear_parity_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (par_q == '0 && npar_q == '0 && code_q == '0));

  p_single_located_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && ((syn ^ nsyn) == '1)) |-> (flags == 3'b001));

  p_erased_clean_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && syn == '1 && nsyn == '1) |-> (flags == 3'b000));

  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !mode_wr |=> ($stable(wide_q) && $stable(size_q)));
endmodule

// File: tb/necc_page_ecc_test.sv
`timescale 1ns/1ps
module necc_page_ecc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_strobe = 1'b0;
  logic        bus_data_phase = 1'b0;
  logic [15:0] bus_dq = '0;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #2.5 clk = ~clk;

  necc_page_ecc uut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe),
    .bus_data_phase(bus_data_phase), .bus_dq(bus_dq), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // reference model state
  int          m_words = 528;
  bit          m_wide = 0;
  logic [1:0]  m_size = 2'd0;
  int          m_cnt = 0;
  int          m_slot = 0;
  bit          m_done = 0;
  logic [15:0] m_p = '0, m_np = '0;
  logic [31:0] m_code = '0;
  logic [15:0] held_beat = '0;

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_slot = 0; m_done = 0; m_p = '0; m_np = '0; m_code = '0;
  endtask

  task automatic model_take(input logic [15:0] d);
    logic [15:0] a;
    if (m_done) return;
    if (m_cnt < m_words) begin
      for (int b = 0; b < (m_wide ? 16 : 8); b++) begin
        if (d[b]) begin
          a = {m_cnt[11:0], b[3:0]};
          m_p  = m_p ^ a;
          m_np = m_np ^ ~a;
        end
      end
      m_cnt++;
    end else begin
      if (m_wide) m_code[16*m_slot +: 16] = d;
      else        m_code[8*m_slot +: 8]   = d[7:0];
      m_slot++;
      if (m_slot == (m_wide ? 2 : 4)) m_done = 1;
    end
  endtask

  function automatic logic [31:0] exp_read(input int sel);
    logic [15:0] s, ns;
    logic [2:0]  st;
    s  = m_p ^ m_code[15:0];
    ns = m_np ^ m_code[31:16];
    if (!m_done)                      st = 3'd0;
    else if (s == 0 && ns == 0)       st = 3'd0;
    else if ((s ^ ns) == 16'hFFFF)    st = 3'd1;
    else if ($countones({s, ns}) == 1) st = 3'd3;
    else if (s == 16'hFFFF)           st = 3'd0;
    else                              st = 3'd5;
    case (sel)
      1: return {27'd0, m_wide, 2'b00, m_size};
      2: return {29'd0, st};
      3: return {16'd0, m_done ? s : m_p};
      4: return {16'd0, m_done ? ns : m_np};
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #0.2;
    v = reg_rdata;
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] v;
    for (int s = 0; s < 6; s++) begin
      rd(s[2:0], v);
      check(tag, v, exp_read(s));
    end
  endtask

  task automatic cyc(input bit strb, input bit dph, input logic [15:0] d,
                     input bit we, input logic [2:0] sel, input logic [31:0] wd,
                     input string tag);
    @(negedge clk);
    bus_strobe = strb; bus_data_phase = dph; bus_dq = d;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    if (we && sel == 3'd0 && wd[0]) model_clear();
    else if (we && sel == 3'd1) begin
      m_size = wd[1:0]; m_wide = wd[4];
      m_words = (528 << m_size) >> (m_wide ? 1 : 0);
      model_clear();
    end else if (strb && dph) model_take(d);
    #0.5;
    bus_strobe = 0; bus_data_phase = 0; reg_we = 0;
    compare_all(tag);
  endtask

  function automatic logic [15:0] word_at(input int seed, input int i, input bit erased);
    logic [15:0] v;
    v = 16'((i * 73 + seed * 151) ^ ((i >> 2) * 9) ^ seed);
    if (erased) v = 16'hFFFF;
    if (!m_wide) v[15:8] = 8'h00;
    return v;
  endfunction

  function automatic logic [31:0] code_of(input int seed, input bit erased);
    logic [15:0] p, np, w, a;
    p = '0; np = '0;
    for (int i = 0; i < m_words; i++) begin
      w = word_at(seed, i, erased);
      for (int b = 0; b < (m_wide ? 16 : 8); b++) begin
        if (w[b]) begin
          a = {i[11:0], b[3:0]};
          p = p ^ a; np = np ^ ~a;
        end
      end
    end
    return {np, p};
  endfunction

  // ncode: number of code beats sent; hold keeps back the final one
  task automatic feed_page(input int seed, input int f1w, input int f1b,
                           input int f2w, input int f2b, input logic [31:0] cx,
                           input bit erased, input int ncode, input bit hold,
                           input string tag);
    logic [31:0] code;
    logic [15:0] w;
    code = code_of(seed, erased) ^ cx;
    for (int i = 0; i < m_words; i++) begin
      w = word_at(seed, i, erased);
      if (i == f1w) w[f1b] = ~w[f1b];
      if (i == f2w) w[f2b] = ~w[f2b];
      cyc(1, 1, w, 0, 3'd0, 32'd0, tag);
      if (i % 97 == 40) begin
        cyc(1, 0, 16'h5AA5, 0, 3'd0, 32'd0, "R3");
        cyc(0, 1, 16'hFFFF, 0, 3'd0, 32'd0, "R3");
      end
    end
    for (int k = 0; k < ncode; k++) begin
      w = m_wide ? code[16*k +: 16] : {8'h00, code[8*k +: 8]};
      if (hold && k == ncode - 1) held_beat = w;
      else cyc(1, 1, w, 0, 3'd0, 32'd0, tag);
    end
  endtask

  task automatic clear_page();
    cyc(0, 0, 16'h0, 1, 3'd0, 32'd1, "R10");
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] ref_code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      rd(s[2:0], v);
      check("R1", v, 32'd0);
    end

    // R2: write-direction accumulation, 528-byte page, 8-bit bus
    cyc(0, 0, 16'h0, 1, 3'd1, 32'h0, "R10");
    feed_page(1, -1, 0, -1, 0, 32'd0, 0, 0, 0, "R2");
    ref_code = code_of(1, 0);
    rd(3'd3, v); check("R2", v, {16'd0, ref_code[15:0]});
    rd(3'd4, v); check("R2", v, {16'd0, ref_code[31:16]});

    // R10: clear wins over a same-cycle beat
    cyc(1, 1, 16'h00FF, 1, 3'd0, 32'd1, "R10");
    rd(3'd3, v); check("R10", v, 32'd0);
    rd(3'd4, v); check("R10", v, 32'd0);

    // R5: clean read
    feed_page(2, -1, 0, -1, 0, 32'd0, 0, 4, 0, "R5");
    rd(3'd2, v); check("R5", v, 32'd0);
    rd(3'd3, v); check("R5", v, 32'd0);

    // R6: single data error, then R11 hold
    clear_page();
    feed_page(3, 300, 5, -1, 0, 32'd0, 0, 4, 0, "R6");
    rd(3'd2, v); check("R6", v, 32'd1);
    rd(3'd3, v); check("R6", v, 32'h12C5);
    rd(3'd4, v); check("R6", v, 32'hED3A);
    cyc(1, 1, 16'h00FF, 0, 3'd0, 32'd0, "R11");
    cyc(1, 1, 16'h0013, 0, 3'd0, 32'd0, "R11");
    cyc(1, 0, 16'h00AA, 0, 3'd0, 32'd0, "R11");
    rd(3'd2, v); check("R11", v, 32'd1);
    rd(3'd2, v); check("R11", v, 32'd1);
    rd(3'd3, v); check("R11", v, 32'h12C5);

    // R7: one bit wrong in stored check parity
    clear_page();
    feed_page(4, -1, 0, -1, 0, 32'h0001_0000, 0, 4, 0, "R7");
    rd(3'd2, v); check("R7", v, 32'd3);

    // R8: two data errors
    clear_page();
    feed_page(5, 10, 1, 200, 6, 32'd0, 0, 4, 0, "R8");
    rd(3'd2, v); check("R8", v, 32'd5);
    rd(3'd3, v); check("R8", v, 32'h0C27);

    // R9: erased page
    clear_page();
    feed_page(6, -1, 0, -1, 0, 32'hFFFF_FFFF ^ code_of(6, 1), 1, 4, 0, "R9");
    rd(3'd2, v); check("R9", v, 32'd0);

    // R4: 1056-byte page, result only after the fourth code byte
    cyc(0, 0, 16'h0, 1, 3'd1, 32'h1, "R4");
    feed_page(7, 1000, 2, -1, 0, 32'd0, 0, 4, 1, "R4");
    rd(3'd2, v); check("R4", v, 32'd0);
    cyc(1, 1, held_beat, 0, 3'd0, 32'd0, "R4");
    rd(3'd2, v); check("R4", v, 32'd1);
    rd(3'd3, v); check("R4", v, 32'h3E82);

    // R12: 16-bit bus, 1056-byte page, error in upper byte
    cyc(0, 0, 16'h0, 1, 3'd1, 32'h11, "R12");
    rd(3'd1, v); check("R12", v, 32'h11);
    feed_page(8, 100, 13, -1, 0, 32'd0, 0, 2, 0, "R12");
    rd(3'd2, v); check("R12", v, 32'd1);
    rd(3'd3, v); check("R12", v, 32'h064D);

    summary();
    $finish;
  end
endmodule